// File: doc/BRIEF.md
# Dual Programmable Feedback Divider

This block holds two independent programmable counters, channel A and channel B. Each one divides the edges of its own oscillator by a 16-bit modulus and emits one pulse per completed divide cycle. A downstream phase comparator uses these pulses. The oscillator edges arrive as one-cycle strobes on a common system clock, so the block has a single clock domain. A channel's divide ratio is its oscillator frequency divided by its pulse rate.

Each modulus arrives on a parallel input with a write strobe. A value below the legal floor of 272 is raised to 272, and an error flag pulses for one clock. A new modulus is held as pending and is loaded only when the running divide cycle completes, so no output period is ever cut short.

A standby bit selects single-loop or dual-loop operation. When standby is set, channel B is frozen, holds its counter at the pending modulus, and drives its pulse low, while channel A keeps running. When standby is clear, both channels divide at the same time. Standby is set after reset.

Top module: `dual_fb_divider`

## Requirements
- R1: Each channel's modulus is a 16-bit unsigned value, bit 0 least significant; a running channel with modulus N produces exactly one output pulse rise per N strobes on its oscillator tick input.
- R2: A modulus written below 272 (including 0) is stored as 272; values from 272 to 65535 are stored unchanged.
- R3: The channel's error output is high for exactly the one clock after a write whose value is below 272, and low after every other cycle.
- R4: A modulus written mid-cycle does not alter the divide cycle in progress; the cycle that follows uses the new value.
- R5: The output pulse rises on the tick that completes a divide cycle and falls on the next tick of that channel, so it stays high for exactly one oscillator period.
- R6: With standby at 1, channel B produces no pulses and holds its pulse output low, while channel A keeps dividing.
- R7: With standby at 0, both channels divide at the same time, each at its own modulus.
- R8: During and after reset, both moduli are 272, standby is 1, and all outputs are low.
- R9: When standby is cleared, channel B starts counting from its full pending modulus, so its first pulse comes exactly N_B ticks later, including when the modulus was written while B was halted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_a | input | 1 | One-clock strobe per channel A oscillator edge |
| tick_b | input | 1 | One-clock strobe per channel B oscillator edge |
| wr_a | input | 1 | Write strobe for channel A modulus |
| mod_a | input | 16 | Channel A modulus value |
| wr_b | input | 1 | Write strobe for channel B modulus |
| mod_b | input | 16 | Channel B modulus value |
| sb_wr | input | 1 | Write strobe for the standby bit |
| sb_val | input | 1 | Standby value: 1 halts channel B, 0 runs both |
| pulse_a | output | 1 | Channel A divide-cycle output pulse |
| pulse_b | output | 1 | Channel B divide-cycle output pulse |
| err_a | output | 1 | One-clock flag: channel A write was clamped |
| err_b | output | 1 | One-clock flag: channel B write was clamped |

## Verification
The hardest case to reach is the boundary between two divide cycles right after a write. To show that the old modulus finishes, the bench must see two pulses after the write: the first period must equal the previous modulus and the second the new one. The bench runs the two oscillators at different tick rates and logs the tick index of every pulse rise, so it measures each period in ticks. Standby is set in the middle of a cycle, a modulus is written while B is halted, and the first B period after release is measured from the exact tick count at which standby was cleared.

// File: rtl/dfd_pkg.sv
package dfd_pkg;
   localparam int DFD_MOD_W_DEF   = 16;
   localparam int DFD_MOD_MIN_DEF = 272;
   localparam int DFD_NUM_CH      = 2;

   typedef enum logic {
      DFD_CH_A = 1'b0,
      DFD_CH_B = 1'b1
   } dfd_ch_e;
endpackage

// File: rtl/dfd_modreg.sv
module dfd_modreg #(
   parameter int MOD_W   = 16,
   parameter int MOD_MIN = 272
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [MOD_W-1:0] din,
   output logic [MOD_W-1:0] pend,
   output logic             err
);
   localparam logic [MOD_W-1:0] MIN_V = MOD_W'(MOD_MIN);

   logic below;
   assign below = (din < MIN_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= MIN_V;
         err  <= 1'b0;
      end else begin
         err <= 1'b0;
         if (wr) begin
            err  <= below;
            pend <= below ? MIN_V : din;
         end
      end
   end
endmodule

// File: rtl/dfd_counter.sv
module dfd_counter #(
   parameter int MOD_W   = 16,
   parameter int MOD_MIN = 272
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [MOD_W-1:0] pend,
   output logic             pulse
);
   localparam logic [MOD_W-1:0] MIN_V = MOD_W'(MOD_MIN);
   localparam logic [MOD_W-1:0] ONE_V = MOD_W'(1);

   logic [MOD_W-1:0] cnt;
   logic             last;

   assign last = (cnt <= ONE_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= MIN_V;
         pulse <= 1'b0;
      end else if (!run) begin
         cnt   <= pend;
         pulse <= 1'b0;
      end else if (tick) begin
         if (last) begin
            cnt   <= pend;
            pulse <= 1'b1;
         end else begin
            cnt   <= cnt - ONE_V;
            pulse <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dual_fb_divider.sv
module dual_fb_divider
   import dfd_pkg::*;
#(
   parameter int MOD_W    = DFD_MOD_W_DEF,
   parameter int MOD_MIN  = DFD_MOD_MIN_DEF,
   parameter bit SB_RESET = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_a,
   input  logic             tick_b,
   input  logic             wr_a,
   input  logic [MOD_W-1:0] mod_a,
   input  logic             wr_b,
   input  logic [MOD_W-1:0] mod_b,
   input  logic             sb_wr,
   input  logic             sb_val,
   output logic             pulse_a,
   output logic             pulse_b,
   output logic             err_a,
   output logic             err_b
);
   localparam int NCH = DFD_NUM_CH;

   if (MOD_W < 2) begin : g_bad_width
      $error("dual_fb_divider: MOD_W must be at least 2");
   end
   if (MOD_MIN < 2 || MOD_MIN >= (1 << MOD_W)) begin : g_bad_min
      $error("dual_fb_divider: MOD_MIN must lie in [2, 2**MOD_W)");
   end

   logic             standby_q;
   logic             tick_v  [NCH];
   logic             wr_v    [NCH];
   logic [MOD_W-1:0] din_v   [NCH];
   logic [MOD_W-1:0] pend_v  [NCH];
   logic             err_v   [NCH];
   logic             pulse_v [NCH];
   logic             run_v   [NCH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     standby_q <= SB_RESET;
      else if (sb_wr) standby_q <= sb_val;
   end

   assign tick_v[DFD_CH_A] = tick_a;
   assign tick_v[DFD_CH_B] = tick_b;
   assign wr_v[DFD_CH_A]   = wr_a;
   assign wr_v[DFD_CH_B]   = wr_b;
   assign din_v[DFD_CH_A]  = mod_a;
   assign din_v[DFD_CH_B]  = mod_b;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      if (ch == int'(DFD_CH_B)) begin : g_gated
         assign run_v[ch] = !standby_q;
      end else begin : g_free
         assign run_v[ch] = 1'b1;
      end

      dfd_modreg #(.MOD_W(MOD_W), .MOD_MIN(MOD_MIN)) u_mod (
         .clk  (clk),
         .rst_n(rst_n),
         .wr   (wr_v[ch]),
         .din  (din_v[ch]),
         .pend (pend_v[ch]),
         .err  (err_v[ch])
      );

      dfd_counter #(.MOD_W(MOD_W), .MOD_MIN(MOD_MIN)) u_cnt (
         .clk  (clk),
         .rst_n(rst_n),
         .run  (run_v[ch]),
         .tick (tick_v[ch]),
         .pend (pend_v[ch]),
         .pulse(pulse_v[ch])
      );
   end

   assign pulse_a = pulse_v[DFD_CH_A];
   assign pulse_b = pulse_v[DFD_CH_B];
   assign err_a   = err_v[DFD_CH_A];
   assign err_b   = err_v[DFD_CH_B];
endmodule

// File: rtl/dual_fb_divider_chk.sv
module dual_fb_divider_chk #(
   parameter int MOD_W   = 16,
   parameter int MOD_MIN = 272
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_a,
   input logic             wr_a,
   input logic [MOD_W-1:0] mod_a,
   input logic             wr_b,
   input logic [MOD_W-1:0] mod_b,
   input logic             sb_wr,
   input logic             sb_val,
   input logic             pulse_a,
   input logic             pulse_b,
   input logic             err_a,
   input logic             err_b
);
   // R3
   err_low_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_a && (mod_a < MOD_W'(MOD_MIN))) |=> err_a);
   // R3
   err_idle_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_a |=> !err_a);
   // R3
   err_low_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_b && (mod_b < MOD_W'(MOD_MIN))) |=> err_b);
   // R2
   err_legal_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_b && (mod_b >= MOD_W'(MOD_MIN))) |=> !err_b);
   // R5
   pulse_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_a && tick_a) |=> !pulse_a);
   // R5
   pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_a |=> $stable(pulse_a));
   // R6
   sb_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sb_wr && sb_val) |-> ##2 !pulse_b);
   // R8
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (!pulse_a && !pulse_b && !err_a && !err_b));
endmodule

bind dual_fb_divider dual_fb_divider_chk #(.MOD_W(MOD_W), .MOD_MIN(MOD_MIN)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .tick_a (tick_a),
   .wr_a   (wr_a),
   .mod_a  (mod_a),
   .wr_b   (wr_b),
   .mod_b  (mod_b),
   .sb_wr  (sb_wr),
   .sb_val (sb_val),
   .pulse_a(pulse_a),
   .pulse_b(pulse_b),
   .err_a  (err_a),
   .err_b  (err_b)
);

// File: tb/sim_dual_fb_divider.sv
`timescale 1ns/1ps
module sim_dual_fb_divider;
   localparam int MIN = 272;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_a = 1'b0, tick_b = 1'b0;
   logic        wr_a = 1'b0, wr_b = 1'b0;
   logic [15:0] mod_a = '0, mod_b = '0;
   logic        sb_wr = 1'b0, sb_val = 1'b0;
   logic        pulse_a, pulse_b, err_a, err_b;

   int checks = 0, fails = 0;
   int cyc = 0, ta = 0, tb = 0;
   int rise_ta = 0, rise_tb = 0, per_a = 0, per_b = 0, per1_a = 0, per1_b = 0;
   int rises_a = 0, rises_b = 0, hi_a = 0;
   bit pa_prev = 1'b0, pb_prev = 1'b0;

   // {mod_a, mod_b, expected stored a, expected stored b}
   localparam logic [63:0] VEC [0:5] = '{
      {16'd272, 16'd300, 16'd272, 16'd300},
      {16'd0,   16'd271, 16'd272, 16'd272},
      {16'd273, 16'd500, 16'd273, 16'd500},
      {16'd700, 16'd1,   16'd700, 16'd272},
      {16'd400, 16'd400, 16'd400, 16'd400},
      {16'd271, 16'd333, 16'd272, 16'd333}
   };

   always #2.5 clk = ~clk;

   dual_fb_divider u0 (
      .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
      .wr_a(wr_a), .mod_a(mod_a), .wr_b(wr_b), .mod_b(mod_b),
      .sb_wr(sb_wr), .sb_val(sb_val),
      .pulse_a(pulse_a), .pulse_b(pulse_b), .err_a(err_a), .err_b(err_b)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   // one clock: sample outputs, then drive the next strobes
   task automatic step(input bit ena, input bit enb);
      @(negedge clk);
      if (pulse_a && !pa_prev) begin
         per_a = ta - rise_ta; rise_ta = ta; rises_a++; hi_a = 0;
         if (rises_a == 1) per1_a = per_a;
      end
      if (!pulse_a && pa_prev) check(hi_a == 1, "R5 ticks while pulse_a high", hi_a, 1);
      if (pulse_b && !pb_prev) begin
         per_b = tb - rise_tb; rise_tb = tb; rises_b++;
         if (rises_b == 1) per1_b = per_b;
      end
      pa_prev = pulse_a;
      pb_prev = pulse_b;
      cyc++;
      tick_a = ena && (cyc % 2 == 0);
      tick_b = enb && (cyc % 3 == 0);
      if (tick_a) begin ta++; if (pulse_a) hi_a++; end
      if (tick_b) tb++;
   endtask

   task automatic write_mods(input logic [15:0] ma, input logic [15:0] mb,
                             input bit do_a, input bit do_b);
      step(0, 0);
      wr_a = do_a; mod_a = ma; wr_b = do_b; mod_b = mb;
      step(0, 0);
      wr_a = 1'b0; wr_b = 1'b0;
      if (do_a) check(err_a == (ma < MIN), "R3 err_a after write", err_a, int'(ma < MIN));
      if (do_b) check(err_b == (mb < MIN), "R3 err_b after write", err_b, int'(mb < MIN));
      step(0, 0);
      check(!err_a && !err_b, "R3 error flags one cycle only", {err_a, err_b}, 0);
      rises_a = 0; rises_b = 0;
   endtask

   task automatic set_sb(input bit v);
      step(0, 0);
      sb_wr = 1'b1; sb_val = v;
      step(0, 0);
      sb_wr = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      int prev_a, prev_b, guard;
      repeat (3) @(negedge clk);
      // R8: outputs quiet during reset
      check(!pulse_a && !pulse_b && !err_a && !err_b, "R8 outputs in reset",
            {pulse_a, pulse_b, err_a, err_b}, 0);
      rst_n = 1'b1;

      // R8 R6: after reset only A runs, modulus 272
      repeat (1200) step(1, 1);
      check(rises_b == 0, "R8 R6 B halted after reset", rises_b, 0);
      check(rises_a == 2, "R8 A pulse count after reset", rises_a, 2);
      check(per_a == MIN, "R1 R8 A period after reset", per_a, MIN);

      // R9 R7: release standby, both run, B from reset modulus
      set_sb(1'b0);
      rise_tb = tb; rises_b = 0; rises_a = 0;
      guard = 0;
      while (rises_b < 1 && guard < 5000) begin step(1, 1); guard++; end
      check(per_b == MIN, "R9 first B period after release", per_b, MIN);
      check(rises_a > 0, "R7 A runs while B runs", rises_a, 1);

      // vector table walk: R1 R2 R4 R7
      prev_a = MIN; prev_b = MIN;
      for (int i = 0; i < 6; i++) begin
         write_mods(VEC[i][63:48], VEC[i][47:32], 1'b1, 1'b1);
         guard = 0;
         while ((rises_a < 2 || rises_b < 2) && guard < 10000) begin step(1, 1); guard++; end
         check(per1_a == prev_a, "R4 A old cycle kept", per1_a, prev_a);
         check(per1_b == prev_b, "R4 B old cycle kept", per1_b, prev_b);
         check(per_a == int'(VEC[i][31:16]), "R1 R2 R7 A period", per_a, int'(VEC[i][31:16]));
         check(per_b == int'(VEC[i][15:0]), "R1 R2 R7 B period", per_b, int'(VEC[i][15:0]));
         prev_a = int'(VEC[i][31:16]);
         prev_b = int'(VEC[i][15:0]);
      end

      // R6: standby set in the middle of a B cycle
      repeat (200) step(1, 1);
      set_sb(1'b1);
      step(1, 1); step(1, 1);
      rises_a = 0; rises_b = 0;
      repeat (2000) step(1, 1);
      check(rises_b == 0, "R6 B silent in standby", rises_b, 0);
      check(pulse_b == 1'b0, "R6 pulse_b low in standby", pulse_b, 0);
      check(rises_a > 0, "R6 A keeps running in standby", rises_a, 1);

      // R9: modulus written while halted, then release
      write_mods(16'd0, 16'd290, 1'b0, 1'b1);
      set_sb(1'b0);
      rise_tb = tb; rises_b = 0;
      guard = 0;
      while (rises_b < 1 && guard < 5000) begin step(1, 1); guard++; end
      check(per_b == 290, "R9 B period after halted write", per_b, 290);

      // R2 R3: upper limit accepted unchanged, no error
      write_mods(16'd65535, 16'd272, 1'b1, 1'b1);
      guard = 0;
      while (rises_b < 2 && guard < 5000) begin step(1, 1); guard++; end
      check(per_b == MIN, "R2 B exact floor kept", per_b, MIN);

      summary();
      $finish;
   end
endmodule